// File: doc/BRIEF.md
# CAN Receive FIFO Pointer Manager

This block sits behind a CAN protocol engine and decides which message-object slot receives each accepted frame. It holds a small array of message objects. Each object has a control word with flags, an arbitration word (identifier and extended-frame flag), an acceptance mask, a function-control word (mode and received DLC), a pointer word, two data words and an interrupt-pointer index. An object in base mode owns a ring of slave objects. Frames it accepts are written into the slave that its current pointer names. The current pointer then steps forward and wraps from the top pointer back to the bottom pointer.

On every frame strobe, all valid objects that have receive enabled and are attached to the node compare the frame against their arbitration and mask words. The object with the highest index among those that accept wins. If the winner is a base object, the frame goes through its ring. If not, the winner stores the frame itself. A slave that has its own receive-enable set while attached to the node therefore takes frames directly, and the ring does not move. Software configures and unloads objects through a flat register port. Writes to the control word use a set/clear form, and the pending vector is write-one-to-clear.

Top module: `can_rxfifo_mgr`

## Requirements
- R1: An object accepts a frame when its valid bit (control bit 0) is set and ((rx word XOR arbitration word) AND mask word) is zero. The rx word has the extended flag at bit 29 and the identifier in bits 28:0, with a standard identifier in bits 28:18. The mask word uses bits 28:0 for the identifier and bit 29 to demand an extended-flag match. A rejected frame changes no state.
- R2: A frame won by a base object (function-control bits 1:0 = 1) is stored in the object whose index equals the base's current pointer. The current pointer then advances by one on every such reception, whatever the slaves' new-data state.
- R3: When the current pointer equals the top pointer, the advance loads the bottom pointer instead.
- R4: A slave (mode 2) that is valid, has receive-enable (control bit 1) set and is attached to the node (control bit 2) competes as an independent object. If it wins, it stores the frame itself and no pointer word changes. The highest-index competing acceptor wins.
- R5: A slave's receive-enable has no effect while its attach bit is clear.
- R6: If no base object wins, the frame goes to the highest-index competing plain object. Rewriting a base's current pointer does not change that choice.
- R7: The target stores the extended flag and identifier into arbitration bits 29:0, the data into the low (selector 5) and high (selector 6) data words, and the DLC into function-control bits 31:24. Its mode bits are kept.
- R8: The target sets new-data (control bit 3) and receive-pending (control bit 4). It also sets message-lost (control bit 5) if new-data was already set.
- R9: A store sets the pending bit indexed by the target's interrupt-pointer field (selector 7). Writing ones to the pending register (object index N_OBJ, selector 0) clears those bits.
- R10: A control-word write sets the flags given in wdata bits 5:0 and clears those given in wdata bits 13:8.
- R11: A register write to a base's pointer word in the same cycle as an advance of that base wins over the advance.
- R12: The pointer word packs bottom in bits 7:0, top in 15:8, current in 23:16 and object-select in 31:24. Register address = object index * 8 + selector, where 4 is the pointer selector. After reset all registers and pending bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a received frame is present |
| rx_ide | input | 1 | Extended-frame flag of the frame |
| rx_id | input | 29 | Frame identifier (standard ID in bits 28:18) |
| rx_dlc | input | 4 | Data length code |
| rx_data | input | 64 | Payload, high word in bits 63:32 |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| msg_pend | output | N_OBJ | Message-pending bits |

## Verification
A frame strobe or register write presented before a rising edge is fully reflected in every object word, pointer and pending bit right after that edge. The read port is combinational. The bench drives each stimulus on a falling edge, removes it on the next falling edge, and then sets the address and samples `rdata` a short delay later. Every check therefore falls one edge after its cause. The checker's properties use the same single-cycle step (`|=>`) for the pointer advance, the wrap, the flag updates and the pending bit.

// File: rtl/can_rxfifo_mgr.sv
module can_rxfifo_mgr #(
  parameter int N_OBJ = 8,
  parameter int AW    = $clog2(N_OBJ) + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_ide,
  input  logic [28:0]      rx_id,
  input  logic [3:0]       rx_dlc,
  input  logic [63:0]      rx_data,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic [N_OBJ-1:0] msg_pend
);
  localparam int IW = $clog2(N_OBJ);
  localparam int OW = AW - 3;
  localparam logic [1:0] MODE_BASE = 2'd1;
  localparam int C_VAL = 0, C_REN = 1, C_NODE = 2, C_NEW = 3, C_PND = 4, C_LOST = 5;

  logic [N_OBJ-1:0][5:0]    ctl_q;
  logic [N_OBJ-1:0][31:0]   arb_q, msk_q, fcr_q, ptr_q, dlo_q, dhi_q;
  logic [N_OBJ-1:0][IW-1:0] ipr_q;
  logic [N_OBJ-1:0]         pend_q, pend_d;

  logic [31:0]   rx_word;
  logic [N_OBJ-1:0] comp;
  logic          hit, win_base, tgt_ok, store, fifo_adv;
  logic [IW-1:0] win, tgt, tgt_pend;
  logic [7:0]    cur, top, bot, nxt_cur;
  logic [OW-1:0] a_obj;
  logic [2:0]    a_sel;

  assign rx_word = {2'b00, rx_ide, rx_id};
  assign a_obj   = addr[AW-1:3];
  assign a_sel   = addr[2:0];

  always_comb begin
    for (int i = 0; i < N_OBJ; i++)
      comp[i] = ctl_q[i][C_VAL] && ctl_q[i][C_REN] && ctl_q[i][C_NODE] &&
                (((rx_word ^ arb_q[i]) & {2'b00, msk_q[i][29:0]}) == 32'd0);
  end

  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int i = 0; i < N_OBJ; i++)
      if (comp[i]) begin
        hit = 1'b1;
        win = IW'(i);
      end
  end

  assign win_base = fcr_q[win][1:0] == MODE_BASE;
  assign bot      = ptr_q[win][7:0];
  assign top      = ptr_q[win][15:8];
  assign cur      = ptr_q[win][23:16];
  assign nxt_cur  = (cur == top) ? bot : cur + 8'd1;
  assign tgt_ok   = !win_base || (cur < 8'(N_OBJ));
  assign tgt      = win_base ? cur[IW-1:0] : win;
  assign tgt_pend = ipr_q[tgt];
  assign store    = rx_valid && hit && tgt_ok;
  assign fifo_adv = store && win_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      arb_q <= '0;
      msk_q <= '0;
      fcr_q <= '0;
      ptr_q <= '0;
      dlo_q <= '0;
      dhi_q <= '0;
      ipr_q <= '0;
    end else begin
      for (int i = 0; i < N_OBJ; i++) begin
        if (store && tgt == IW'(i)) begin
          arb_q[i][29:0]  <= rx_word[29:0];
          dlo_q[i]        <= rx_data[31:0];
          dhi_q[i]        <= rx_data[63:32];
          fcr_q[i][31:24] <= {4'd0, rx_dlc};
          ctl_q[i][C_NEW] <= 1'b1;
          ctl_q[i][C_PND] <= 1'b1;
          if (ctl_q[i][C_NEW]) ctl_q[i][C_LOST] <= 1'b1;
        end
        if (fifo_adv && win == IW'(i))
          ptr_q[i][23:16] <= nxt_cur;
        if (wr_en && a_obj == OW'(i)) begin
          case (a_sel)
            3'd0: ctl_q[i] <= (ctl_q[i] & ~wdata[13:8]) | wdata[5:0];
            3'd1: arb_q[i] <= wdata;
            3'd2: msk_q[i] <= wdata;
            3'd3: fcr_q[i] <= wdata;
            3'd4: ptr_q[i] <= wdata;
            3'd5: dlo_q[i] <= wdata;
            3'd6: dhi_q[i] <= wdata;
            default: ipr_q[i] <= wdata[IW-1:0];
          endcase
        end
      end
    end
  end

  always_comb begin
    pend_d = pend_q;
    if (wr_en && a_obj == OW'(N_OBJ) && a_sel == 3'd0)
      pend_d = pend_d & ~wdata[N_OBJ-1:0];
    if (store)
      pend_d[tgt_pend] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;

  assign msg_pend = pend_q;

  always_comb begin
    rdata = 32'd0;
    if (a_obj == OW'(N_OBJ)) begin
      if (a_sel == 3'd0) rdata = 32'(pend_q);
    end else if (a_obj < OW'(N_OBJ)) begin
      case (a_sel)
        3'd0: rdata = 32'(ctl_q[a_obj[IW-1:0]]);
        3'd1: rdata = arb_q[a_obj[IW-1:0]];
        3'd2: rdata = msk_q[a_obj[IW-1:0]];
        3'd3: rdata = fcr_q[a_obj[IW-1:0]];
        3'd4: rdata = ptr_q[a_obj[IW-1:0]];
        3'd5: rdata = dlo_q[a_obj[IW-1:0]];
        3'd6: rdata = dhi_q[a_obj[IW-1:0]];
        default: rdata = 32'(ipr_q[a_obj[IW-1:0]]);
      endcase
    end
  end
endmodule

// File: rtl/can_rxfifo_chk.sv
module can_rxfifo_chk #(
  parameter int N_OBJ = 8,
  parameter int IW    = 3,
  parameter int AW    = 7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rx_valid,
  input logic                   wr_en,
  input logic [AW-1:0]          addr,
  input logic [31:0]            wdata,
  input logic                   store,
  input logic                   fifo_adv,
  input logic [IW-1:0]          win,
  input logic [IW-1:0]          tgt,
  input logic [IW-1:0]          tgt_pend,
  input logic [N_OBJ-1:0][31:0] ptr_q,
  input logic [N_OBJ-1:0][5:0]  ctl_q,
  input logic [N_OBJ-1:0]       msg_pend
);
  logic ptr_wr;
  assign ptr_wr = wr_en && addr[2:0] == 3'd4 && addr[AW-1:3] < (AW-3)'(N_OBJ);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !wr_en) |=> ($stable(ptr_q) && $stable(ctl_q)));

  p_ring_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_adv && !wr_en) |=> ptr_q[$past(win)][23:16] ==
      (($past(ptr_q[win][23:16]) == $past(ptr_q[win][15:8])) ?
        $past(ptr_q[win][7:0]) : $past(ptr_q[win][23:16]) + 8'd1));

  p_direct_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (store && !fifo_adv && !wr_en) |=> $stable(ptr_q));

  p_flags_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (store && !wr_en) |=> (ctl_q[$past(tgt)][3] && ctl_q[$past(tgt)][4]));

  p_pend_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> msg_pend[$past(tgt_pend)]);

  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> ptr_q[$past(addr[IW+2:3])] == $past(wdata));
endmodule

bind can_rxfifo_mgr can_rxfifo_chk #(.N_OBJ(N_OBJ), .IW(IW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .store(store), .fifo_adv(fifo_adv), .win(win), .tgt(tgt),
  .tgt_pend(tgt_pend), .ptr_q(ptr_q), .ctl_q(ctl_q), .msg_pend(msg_pend)
);

// File: tb/test_can_rxfifo_mgr.sv
module test_can_rxfifo_mgr;
  localparam int PERIOD = 10;
  localparam int N_OBJ  = 8;
  localparam int AW     = 7;
  localparam logic [28:0] ID50 = 29'(11'h050) << 18;
  localparam logic [31:0] MSK  = 32'h3FFC0000;

  logic clk = 0, rst_n = 0, rx_valid = 0, rx_ide = 0, wr_en = 0;
  logic [28:0] rx_id = '0;
  logic [3:0]  rx_dlc = '0;
  logic [63:0] rx_data = '0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [N_OBJ-1:0] msg_pend;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  can_rxfifo_mgr #(.N_OBJ(N_OBJ), .AW(AW)) i_can_rxfifo_mgr (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [AW-1:0] ra(int obj, int sel);
    return AW'(obj * 8 + sel);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic rd_chk(string req, int obj, int sel, logic [31:0] exp);
    @(negedge clk);
    addr = ra(obj, sel);
    #1 chk(req, rdata, exp);
  endtask

  task automatic wr(int obj, int sel, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = ra(obj, sel); wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic put_frame(int n, logic ide, logic [28:0] id);
    rx_valid = 1; rx_ide = ide; rx_id = id; rx_dlc = 4'(n);
    rx_data = {32'hE0000000 + 32'(n), 32'hD0000000 + 32'(n)};
  endtask

  task automatic frame(int n, logic ide, logic [28:0] id);
    @(negedge clk);
    put_frame(n, ide, id);
    @(negedge clk);
    rx_valid = 0;
  endtask

  function automatic logic [31:0] dlo(int n);
    return 32'hD0000000 + 32'(n);
  endfunction

  task automatic t_reset;
    rd_chk("R12 reset ptr", 2, 4, 0);
    rd_chk("R12 reset ctl", 3, 0, 0);
    rd_chk("R12 reset pend", N_OBJ, 0, 0);
  endtask

  task automatic t_setup;
    wr(2, 0, 32'h07); wr(2, 1, 32'(ID50)); wr(2, 2, MSK); wr(2, 3, 32'd1);
    wr(2, 4, 32'h05030503);
    for (int i = 3; i <= 5; i++) begin
      wr(i, 0, 32'h05); wr(i, 3, 32'd2); wr(i, 7, 32'(i));
    end
    rd_chk("R12 pointer word", 2, 4, 32'h05030503);
  endtask

  task automatic t_fifo_fill;
    frame(1, 0, ID50);
    rd_chk("R2 slot3 data", 3, 5, dlo(1));
    rd_chk("R7 slot3 high data", 3, 6, 32'hE0000001);
    rd_chk("R7 slot3 arb", 3, 1, 32'h01400000);
    rd_chk("R7 slot3 dlc+mode", 3, 3, 32'h01000002);
    rd_chk("R8 slot3 flags", 3, 0, 32'h1D);
    rd_chk("R2 cur advanced", 2, 4, 32'h05040503);
    rd_chk("R9 pend bit3", N_OBJ, 0, 32'h08);
    frame(2, 0, ID50);
    frame(3, 0, ID50);
    rd_chk("R2 slot4 data", 4, 5, dlo(2));
    rd_chk("R2 slot5 data", 5, 5, dlo(3));
    rd_chk("R3 wrap to bottom", 2, 4, 32'h05030503);
    rd_chk("R9 pend bits 3..5", N_OBJ, 0, 32'h38);
    frame(4, 0, ID50);
    rd_chk("R2 overwrite when full", 3, 5, dlo(4));
    rd_chk("R8 msglost set", 3, 0, 32'h3D);
    rd_chk("R2 cur advances when full", 2, 4, 32'h05040503);
  endtask

  task automatic t_reject;
    frame(9, 0, 29'(11'h051) << 18);
    rd_chk("R1 id mismatch ptr", 2, 4, 32'h05040503);
    rd_chk("R1 id mismatch data", 4, 5, dlo(2));
    frame(10, 1, ID50);
    rd_chk("R1 ide mismatch ptr", 2, 4, 32'h05040503);
    rd_chk("R1 ide mismatch data", 4, 5, dlo(2));
  endtask

  task automatic t_clear;
    wr(3, 0, 32'h3800);
    rd_chk("R10 flag clear", 3, 0, 32'h05);
    wr(3, 0, 32'h0008);
    rd_chk("R10 flag set", 3, 0, 32'h0D);
    wr(3, 0, 32'h0800);
    wr(N_OBJ, 0, 32'hFF);
    rd_chk("R9 pend clear", N_OBJ, 0, 32'h00);
  endtask

  task automatic t_write_race;
    @(negedge clk);
    put_frame(5, 0, ID50);
    wr_en = 1; addr = ra(2, 4); wdata = 32'h05030503;
    @(negedge clk);
    rx_valid = 0; wr_en = 0;
    rd_chk("R11 write beats advance", 2, 4, 32'h05030503);
    rd_chk("R11 frame still stored", 4, 5, dlo(5));
  endtask

  task automatic t_direct_slave;
    wr(5, 1, 32'(ID50)); wr(5, 2, MSK); wr(5, 0, 32'h02);
    frame(6, 0, ID50);
    rd_chk("R4 slave takes frame", 5, 5, dlo(6));
    rd_chk("R4 cur unchanged", 2, 4, 32'h05030503);
    rd_chk("R4 ring slot untouched", 3, 5, dlo(4));
    rd_chk("R4 slave flags", 5, 0, 32'h3F);
  endtask

  task automatic t_detached_slave;
    wr(5, 0, 32'h0400);
    frame(7, 0, ID50);
    rd_chk("R5 ring used", 3, 5, dlo(7));
    rd_chk("R5 cur advanced", 2, 4, 32'h05040503);
    rd_chk("R5 slave untouched", 5, 5, dlo(6));
  endtask

  task automatic t_plain;
    wr(2, 0, 32'h0200);
    for (int i = 6; i <= 7; i++) begin
      wr(i, 1, 32'(ID50)); wr(i, 2, MSK); wr(i, 7, 32'd1); wr(i, 0, 32'h07);
    end
    frame(8, 0, ID50);
    rd_chk("R6 highest object wins", 7, 5, dlo(8));
    rd_chk("R6 lower object idle", 6, 5, 0);
    rd_chk("R6 ptr unchanged", 2, 4, 32'h05040503);
    rd_chk("R9 pend via index 1", N_OBJ, 0, 32'h3A);
    wr(2, 4, 32'h05050503);
    frame(9, 0, ID50);
    rd_chk("R6 cur rewrite ignored", 7, 5, dlo(9));
    rd_chk("R6 slot5 untouched", 5, 5, dlo(6));
    rd_chk("R6 ptr kept", 2, 4, 32'h05050503);
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_reset;
    t_setup;
    t_fifo_fill;
    t_reject;
    t_clear;
    t_write_race;
    t_direct_slave;
    t_detached_slave;
    t_plain;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule